// File: doc/BRIEF.md
# Programmable Match-Reset Frequency Divider

This block divides an audio-rate clock enable by a programmable ratio. It keeps a 5-bit counter that moves forward by one on each enabled tick. It compares that counter with a 5-bit frequency value that software writes. When the two are equal, the counter returns to zero on the next enabled tick instead of moving forward. A frequency value of N therefore gives a period of N+1 ticks. A value of zero keeps the counter at zero, so the output pulses on every tick.

The equality result passes through one register stage before it acts on the counter. This stage stands in for the delay of the comparison path. The block also drives a terminal pulse that is one enabled tick wide. It marks the tick on which the counter is cleared, and the tone or noise logic that follows can use it as its divided clock. Enable pulses must be separated by at least one idle clock, which is how a phase-type audio enable behaves. A write to the frequency register governs every enabled tick that arrives two or more clocks after the write.

Top module: `tone_divider`

## Requirements
- R1: A synchronous reset sets the counter, the delayed match and the frequency register to zero. After reset, with no write, the counter stays at 0 on every tick.
- R2: When the audio enable is low, the counter holds its value.
- R3: On an enabled tick without a pending match, the counter increments by one. It wraps from 31 to 0.
- R4: On an enabled tick where the counter equals the frequency value (all 5 bits agree), the counter becomes 0. The period is the frequency value plus one. A value of 0 keeps the counter at 0.
- R5: The terminal pulse is high only during an enabled tick on which the counter is cleared. It is high for exactly one tick per period.
- R6: A written frequency value takes effect for enabled ticks two or more clocks after the write. If the new value is below the current count, the counter runs up to 31, wraps to 0, and then counts to the new value.
- R7: The audio enable is never high on two consecutive clocks.
- R8: A frequency value of 31 gives a period of 32 ticks, covering counts 0 through 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the frequency register |
| wr_data | input | 5 | New frequency value |
| aud_en | input | 1 | Audio-rate tick enable (phase-2 tick) |
| count | output | 5 | Current divider count |
| term_pulse | output | 1 | High during the enabled tick on which the counter clears |

## Verification
The assertions check the following on every cycle:
- the counter holds while idle;
- it clears after a tick with a pending match;
- it increments after a tick without one;
- the pulse appears only with the enable;
- enable pulses are spaced correctly;
- reset clears the counter.

The bench scenarios are needed for everything that depends on the frequency value over a whole period. This covers the exact period for the values 0, 1, 3 and 31, the wrap that follows a write below the current count, and the fact that reset also zeroes the frequency register.

// File: rtl/tone_div_pkg.sv
package tone_div_pkg;
  parameter int CNT_W = 5;
  typedef logic [CNT_W-1:0] cnt_t;

  // next counter value for an enabled tick
  function automatic cnt_t step_count(input cnt_t cur, input logic clr);
    cnt_t nxt;
    if (clr) nxt = '0;
    else     nxt = cur + cnt_t'(1);
    return nxt;
  endfunction

  // equality as a wide NOR over disagreeing bits
  function automatic logic bits_agree(input cnt_t a, input cnt_t b);
    return ~|(a ^ b);
  endfunction
endpackage

// File: rtl/freq_store.sv
module freq_store
  import tone_div_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  cnt_t wr_data,
  output cnt_t freq
);
  always_ff @(posedge clk) begin
    if (rst)        freq <= '0;
    else if (wr_en) freq <= wr_data;
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> freq == $past(wr_data)); // R6
endmodule

// File: rtl/match_stage.sv
module match_stage
  import tone_div_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cnt_t cnt,
  input  cnt_t freq,
  output logic match_q
);
  logic match_now;
  assign match_now = bits_agree(cnt, freq);

  // one register stage models the comparison-path delay
  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b0;
    else     match_q <= match_now;
  end
endmodule

// File: rtl/count_stage.sv
module count_stage
  import tone_div_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic clr_req,
  output cnt_t cnt
);
  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (tick_en) cnt <= step_count(cnt, clr_req);
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(cnt)); // R2
  AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !clr_req) |=> cnt == cnt_t'($past(cnt) + 1'b1)); // R3
  AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (tick_en && clr_req) |=> cnt == '0); // R4
endmodule

// File: rtl/tone_divider.sv
module tone_divider
  import tone_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             aud_en,
  output logic [CNT_W-1:0] count,
  output logic             term_pulse
);
  cnt_t freq_w;
  cnt_t cnt_w;
  logic match_q_w;
  logic clear_evt;

  freq_store u_freq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .freq(freq_w)
  );

  match_stage u_match (
    .clk(clk), .rst(rst), .cnt(cnt_w), .freq(freq_w), .match_q(match_q_w)
  );

  count_stage u_count (
    .clk(clk), .rst(rst), .tick_en(aud_en), .clr_req(match_q_w), .cnt(cnt_w)
  );

  assign clear_evt  = aud_en & match_q_w;
  assign count      = cnt_w;
  assign term_pulse = clear_evt;

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> count == '0); // R1
  AST_PULSE_WITH_EN: assert property (@(posedge clk) disable iff (rst)
    term_pulse |-> aud_en); // R5
  AST_PULSE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    term_pulse |=> count == '0); // R5
  AST_EN_SPACING: assert property (@(posedge clk) disable iff (rst)
    aud_en |=> !aud_en); // R7
endmodule

// File: tb/tone_divider_test.sv
module tone_divider_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [4:0] wr_data = '0;
  logic       aud_en = 1'b0;
  logic [4:0] count;
  logic       term_pulse;

  int checks = 0;
  int errors = 0;
  logic [4:0] exp_cnt = '0;
  logic [4:0] exp_freq = '0;

  tone_divider uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .aud_en(aud_en), .count(count), .term_pulse(term_pulse)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one enabled tick, then idle clocks; checks pulse and resulting count
  task automatic do_tick(input string req);
    logic exp_p;
    @(negedge clk);
    aud_en = 1'b1;
    #1;
    exp_p = (exp_cnt == exp_freq);
    check({req, " pulse"}, term_pulse, exp_p);
    @(negedge clk);
    aud_en = 1'b0;
    exp_cnt = exp_p ? 5'd0 : exp_cnt + 5'd1;
    check({req, " count"}, count, exp_cnt);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic write_freq(input logic [4:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    exp_freq = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    exp_cnt = '0; exp_freq = '0;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 count", count, 0);
    check("R1 pulse idle", term_pulse, 0);
    for (int i = 0; i < 3; i++) do_tick("R1 freq zero");
  endtask

  task automatic t_hold();
    write_freq(5'd7);
    do_tick("R3");
    do_tick("R3");
    repeat (6) @(negedge clk);
    check("R2 hold", count, exp_cnt);
    check("R5 no pulse idle", term_pulse, 0);
  endtask

  task automatic t_period(input logic [4:0] v, input string req);
    int pulses;
    do_reset();
    write_freq(v);
    pulses = 0;
    for (int i = 0; i < 2 * (v + 1); i++) begin
      if (exp_cnt == exp_freq) pulses++;
      do_tick(req);
    end
    check({req, " pulses per two periods"}, pulses, 2);
  endtask

  task automatic t_write_below();
    do_reset();
    write_freq(5'd9);
    for (int i = 0; i < 6; i++) do_tick("R6 pre");
    check("R6 count before write", count, 6);
    write_freq(5'd2);
    for (int i = 0; i < 32; i++) do_tick("R6 wrap");
    check("R6 after wrap", count, exp_cnt);
  endtask

  task automatic t_reset_clears_freq();
    write_freq(5'd4);
    do_tick("R1 pre");
    do_reset();
    for (int i = 0; i < 3; i++) do_tick("R1 freq cleared");
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_hold();
    t_period(5'd0, "R4 n0");
    t_period(5'd1, "R4 n1");
    t_period(5'd3, "R4 n3");
    t_period(5'd31, "R8");
    t_write_below();
    t_reset_clears_freq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule